// File: doc/BRIEF.md
# Per-Master Aperture Address Remapper

This block sits between a set of bus masters and the system interconnect. For every master it holds a routing table that splits the 32-bit address space into sixteen apertures of 256 MB each. The aperture is picked by address bits [31:28]. For each aperture the table gives a 4-bit target slave code and a 4-bit replacement for the upper address nibble. Each master presents an address. The block returns, for that master, the target slave code, the remapped address and a decode-error flag. The decode path is purely combinational from the committed tables.

Software programs the tables through a small 32-bit register port, and writes land in a staged copy. A master's staged copy becomes active only when the value 1 is written to that master's update register, so one master can be reconfigured without disturbing the others. Master 0 also has a boot register. While that register's boot-mirror bits are set, aperture 0 of master 0 is redirected to a fixed boot slave. A separate global address-extension word has its own staged copy and its own commit register, and its committed value is driven on an output.

Top module: `aperture_remap`

## Requirements
- R1: For master m, the aperture index n is m_addr[31:28]. The slave code is taken from nibble (n mod 8) of select word 1 (register offset +0x04) for n < 8, and from the same nibble of select word 0 (offset +0x00) for n >= 8, using the committed table.
- R2: The remapped address carries the committed offset nibble for aperture n in bits [31:28], taken from offset word 1 (+0x0C) for n < 8 and from offset word 0 (+0x08) for n >= 8. Bits [27:0] pass through unchanged.
- R3: A slave code of 0, or any code from 11 to 15, raises the decode-error flag and drives slave code 0. Codes 1 to 10 are driven as-is with the flag low.
- R4: Writes to a master's select or offset registers have no effect on its decode outputs until the value 1 is written to its update register (+0x14). Writing any other value to the update register commits nothing.
- R5: Master m's registers sit at byte address m*0x20 plus an offset. Reading a select or offset register returns the staged value. The update registers (+0x14, 0x194) read as 0. Unmapped addresses read as 0.
- R6: After reset, every master's staged and committed select words are 0x77777777, its offset words are 0xFEDCBA98 (word 0) and 0x76543210 (word 1), the boot bits are 2'b11, and the extension word is 0.
- R7: The boot register at +0x10 of master 0 keeps bits [1:0], takes effect at once, and reads back zero-extended. While either bit is set, aperture 0 of master 0 routes to slave code 5 with its address unchanged and no error. Clearing both bits restores table decoding. Other masters have no boot register.
- R8: The extension word at 0x180 is staged. Its committed value on ext_cfg changes only when the value 1 is written to 0x194.
- R9: An update strobe for one master leaves every other master's committed table untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| m_addr | input | N_MASTERS*32 | Incoming address per master, master m at bits [m*32 +: 32] |
| m_slave | output | N_MASTERS*4 | Target slave code per master |
| m_raddr | output | N_MASTERS*32 | Remapped address per master |
| m_derr | output | N_MASTERS | Decode error per master |
| ext_cfg | output | 32 | Committed address-extension word |

## Verification
The assertions assume that reg_wr, reg_addr and reg_wdata are held steady for a whole clock period and never carry unknown values outside reset. They also assume that a master's output can change only through its own update or boot write or through a change of its input address. The bench drives every input on the falling edge from a single task, so each register access lasts exactly one cycle. It keeps reg_wr low during reset and varies the master addresses deterministically, so every aperture of every master is visited every sixteen cycles.

// File: rtl/ar_pkg.sv
package ar_pkg;

   localparam int ADDR_W  = 32;
   localparam int NIB_W   = 4;
   localparam int TBL_W   = 16 * NIB_W;
   localparam int WORD_W  = 32;
   localparam int MAX_CODE = 10;

   typedef logic [NIB_W-1:0]  nib_t;
   typedef logic [TBL_W-1:0]  tbl_t;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [2:0] {
      W_SEL0 = 3'd0,
      W_SEL1 = 3'd1,
      W_OFS0 = 3'd2,
      W_OFS1 = 3'd3,
      W_BOOT = 3'd4,
      W_UPD  = 3'd5
   } word_e;

   function automatic nib_t nib_at(input tbl_t tbl, input nib_t idx);
      return tbl[{idx, 2'b00} +: NIB_W];
   endfunction

endpackage

// File: rtl/ar_slot.sv
module ar_slot
   import ar_pkg::*;
#(
   parameter bit    HAS_BOOT = 1'b0,
   parameter word_t DEF_SEL0 = 32'h7777_7777,
   parameter word_t DEF_SEL1 = 32'h7777_7777,
   parameter word_t DEF_OFS0 = 32'hFEDC_BA98,
   parameter word_t DEF_OFS1 = 32'h7654_3210,
   parameter logic [1:0] DEF_BOOT = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] widx,
   input  word_t      wdata,
   output word_t      stg_sel0,
   output word_t      stg_sel1,
   output word_t      stg_ofs0,
   output word_t      stg_ofs1,
   output tbl_t       cmt_sel,
   output tbl_t       cmt_ofs,
   output logic [1:0] boot_bits
);

   logic do_commit;
   assign do_commit = wr_en && (widx == W_UPD) && (wdata == word_t'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_sel0 <= DEF_SEL0;
         stg_sel1 <= DEF_SEL1;
         stg_ofs0 <= DEF_OFS0;
         stg_ofs1 <= DEF_OFS1;
      end else if (wr_en) begin
         case (widx)
            W_SEL0:  stg_sel0 <= wdata;
            W_SEL1:  stg_sel1 <= wdata;
            W_OFS0:  stg_ofs0 <= wdata;
            W_OFS1:  stg_ofs1 <= wdata;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmt_sel <= {DEF_SEL0, DEF_SEL1};
         cmt_ofs <= {DEF_OFS0, DEF_OFS1};
      end else if (do_commit) begin
         cmt_sel <= {stg_sel0, stg_sel1};
         cmt_ofs <= {stg_ofs0, stg_ofs1};
      end
   end

   generate
      if (HAS_BOOT) begin : g_boot
         logic [1:0] boot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               boot_q <= DEF_BOOT;
            else if (wr_en && widx == W_BOOT)
               boot_q <= wdata[1:0];
         end
         assign boot_bits = boot_q;
      end else begin : g_noboot
         assign boot_bits = 2'b00;
      end
   endgenerate

endmodule

// File: rtl/ar_lookup.sv
module ar_lookup
   import ar_pkg::*;
#(
   parameter nib_t BOOT_SLAVE = 4'd5
) (
   input  logic [ADDR_W-1:0] addr,
   input  tbl_t              sel,
   input  tbl_t              ofs,
   input  logic              mirror,
   output nib_t              slave,
   output logic [ADDR_W-1:0] raddr,
   output logic              derr
);

   nib_t ap;
   nib_t code;
   logic bad;

   assign ap   = addr[ADDR_W-1 -: NIB_W];
   assign code = nib_at(sel, ap);
   assign bad  = (code == '0) || (code > nib_t'(MAX_CODE));

   always_comb begin
      if (mirror && ap == '0) begin
         slave = BOOT_SLAVE;
         raddr = addr;
         derr  = 1'b0;
      end else begin
         slave = bad ? '0 : code;
         raddr = {nib_at(ofs, ap), addr[ADDR_W-NIB_W-1:0]};
         derr  = bad;
      end
   end

endmodule

// File: rtl/ar_ext.sv
module ar_ext
   import ar_pkg::*;
#(
   parameter word_t DEF_EXT = '0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_val,
   input  logic  wr_upd,
   input  word_t wdata,
   output word_t stg,
   output word_t cmt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= DEF_EXT;
         cmt <= DEF_EXT;
      end else begin
         if (wr_val)
            stg <= wdata;
         if (wr_upd && wdata == word_t'(1))
            cmt <= stg;
      end
   end

endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
   import ar_pkg::*;
#(
   parameter int    N_MASTERS  = 12,
   parameter int    RA_W       = 12,
   parameter word_t DEF_SEL0   = 32'h7777_7777,
   parameter word_t DEF_SEL1   = 32'h7777_7777,
   parameter word_t DEF_OFS0   = 32'hFEDC_BA98,
   parameter word_t DEF_OFS1   = 32'h7654_3210,
   parameter logic [1:0] DEF_BOOT = 2'b11,
   parameter word_t DEF_EXT    = 32'h0000_0000,
   parameter nib_t  BOOT_SLAVE = 4'd5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [RA_W-1:0]           reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   input  logic [N_MASTERS*32-1:0]   m_addr,
   output logic [N_MASTERS*4-1:0]    m_slave,
   output logic [N_MASTERS*32-1:0]   m_raddr,
   output logic [N_MASTERS-1:0]      m_derr,
   output logic [31:0]               ext_cfg
);

   localparam int GW       = RA_W - 5;
   localparam int WA_W     = RA_W - 2;
   localparam int EXT_WORD = 'h180 >> 2;
   localparam int EXU_WORD = 'h194 >> 2;

   generate
      if (N_MASTERS < 1 || N_MASTERS > 12) begin : g_bad_cnt
         $error("aperture_remap: N_MASTERS must be 1..12 to stay below 0x180");
      end
      if (RA_W < 9) begin : g_bad_aw
         $error("aperture_remap: RA_W must reach address 0x194");
      end
      if (BOOT_SLAVE == 0 || BOOT_SLAVE > MAX_CODE) begin : g_bad_boot
         $error("aperture_remap: BOOT_SLAVE must be a valid slave code");
      end
   endgenerate

   logic [GW-1:0]   grp;
   logic [2:0]      widx;
   logic [WA_W-1:0] waddr;
   logic            unused_lsb;

   assign grp        = reg_addr[RA_W-1:5];
   assign widx       = reg_addr[4:2];
   assign waddr      = reg_addr[RA_W-1:2];
   assign unused_lsb = ^reg_addr[1:0];

   word_t      st_sel0 [N_MASTERS];
   word_t      st_sel1 [N_MASTERS];
   word_t      st_ofs0 [N_MASTERS];
   word_t      st_ofs1 [N_MASTERS];
   tbl_t       c_sel   [N_MASTERS];
   tbl_t       c_ofs   [N_MASTERS];
   logic [1:0] boot    [N_MASTERS];

   genvar m;
   generate
      for (m = 0; m < N_MASTERS; m++) begin : g_m
         ar_slot #(
            .HAS_BOOT (m == 0),
            .DEF_SEL0 (DEF_SEL0),
            .DEF_SEL1 (DEF_SEL1),
            .DEF_OFS0 (DEF_OFS0),
            .DEF_OFS1 (DEF_OFS1),
            .DEF_BOOT (DEF_BOOT)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_wr && grp == GW'(m)),
            .widx      (widx),
            .wdata     (reg_wdata),
            .stg_sel0  (st_sel0[m]),
            .stg_sel1  (st_sel1[m]),
            .stg_ofs0  (st_ofs0[m]),
            .stg_ofs1  (st_ofs1[m]),
            .cmt_sel   (c_sel[m]),
            .cmt_ofs   (c_ofs[m]),
            .boot_bits (boot[m])
         );

         ar_lookup #(
            .BOOT_SLAVE (BOOT_SLAVE)
         ) u_lookup (
            .addr   (m_addr[m*32 +: 32]),
            .sel    (c_sel[m]),
            .ofs    (c_ofs[m]),
            .mirror (boot[m] != 2'b00),
            .slave  (m_slave[m*4 +: 4]),
            .raddr  (m_raddr[m*32 +: 32]),
            .derr   (m_derr[m])
         );
      end
   endgenerate

   word_t ext_stg;

   ar_ext #(
      .DEF_EXT (DEF_EXT)
   ) u_ext (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_val (reg_wr && waddr == WA_W'(EXT_WORD)),
      .wr_upd (reg_wr && waddr == WA_W'(EXU_WORD)),
      .wdata  (reg_wdata),
      .stg    (ext_stg),
      .cmt    (ext_cfg)
   );

   always_comb begin
      reg_rdata = '0;
      if (waddr == WA_W'(EXT_WORD))
         reg_rdata = ext_stg;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (grp == GW'(i)) begin
            case (widx)
               W_SEL0:  reg_rdata = st_sel0[i];
               W_SEL1:  reg_rdata = st_sel1[i];
               W_OFS0:  reg_rdata = st_ofs0[i];
               W_OFS1:  reg_rdata = st_ofs1[i];
               W_BOOT:  reg_rdata = {30'd0, boot[i]};
               default: reg_rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/ar_chk.sv
module ar_chk #(
   parameter int N_MASTERS  = 12,
   parameter int RA_W       = 12,
   parameter logic [3:0] BOOT_SLAVE = 4'd5
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_wr,
   input logic [RA_W-1:0]         reg_addr,
   input logic [31:0]             reg_wdata,
   input logic [31:0]             reg_rdata,
   input logic [N_MASTERS*32-1:0] m_addr,
   input logic [N_MASTERS*4-1:0]  m_slave,
   input logic [N_MASTERS*32-1:0] m_raddr,
   input logic [N_MASTERS-1:0]    m_derr,
   input logic [31:0]             ext_cfg
);

   localparam int WA_W = RA_W - 2;

   logic [WA_W-1:0] waddr;
   assign waddr = reg_addr[RA_W-1:2];

   genvar m;
   generate
      for (m = 0; m < N_MASTERS; m++) begin : g_m
         // R2
         low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_raddr[m*32 +: 28] == m_addr[m*32 +: 28]);

         // R3
         derr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_derr[m] |-> m_slave[m*4 +: 4] == 4'd0);

         // R3
         code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            m_slave[m*4 +: 4] <= 4'd10);

         // R4 R9
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!(reg_wr && waddr == WA_W'(m*8 + 5))) &&
             $past(!(reg_wr && waddr == WA_W'(4))) &&
             $stable(m_addr[m*32 +: 32]))
            |-> ($stable(m_slave[m*4 +: 4]) && $stable(m_raddr[m*32 +: 32]) &&
                 $stable(m_derr[m])));

         // R5
         upd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr[RA_W-1:5] == (RA_W-5)'(m) && reg_addr[4:2] == 3'd5)
            |-> reg_rdata == 32'd0);
      end
   endgenerate

   // R7
   boot_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_wr && waddr == WA_W'(4) && reg_wdata[1:0] != 2'b00) &&
       m_addr[31:28] == 4'd0)
      |-> (m_slave[3:0] == BOOT_SLAVE && !m_derr[0] && m_raddr[31:0] == m_addr[31:0]));

   // R8
   ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(reg_wr && waddr == WA_W'('h194 >> 2) && reg_wdata == 32'd1))
      |-> $stable(ext_cfg));

   // R5
   ext_upd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (waddr == WA_W'('h194 >> 2)) |-> reg_rdata == 32'd0);

endmodule

bind aperture_remap ar_chk #(
   .N_MASTERS  (N_MASTERS),
   .RA_W       (RA_W),
   .BOOT_SLAVE (BOOT_SLAVE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .m_addr    (m_addr),
   .m_slave   (m_slave),
   .m_raddr   (m_raddr),
   .m_derr    (m_derr),
   .ext_cfg   (ext_cfg)
);

// File: tb/aperture_remap_tb.sv
`timescale 1ns/1ps
module aperture_remap_tb;

   localparam int N    = 12;
   localparam int RA_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [RA_W-1:0]   reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic [N*32-1:0]   m_addr = '0;
   logic [N*4-1:0]    m_slave;
   logic [N*32-1:0]   m_raddr;
   logic [N-1:0]      m_derr;
   logic [31:0]       ext_cfg;

   always #5 clk = ~clk;

   aperture_remap #(.N_MASTERS(N), .RA_W(RA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_addr(m_addr),
      .m_slave(m_slave), .m_raddr(m_raddr), .m_derr(m_derr), .ext_cfg(ext_cfg)
   );

   // behavioural reference state
   logic [31:0] s_sel0 [N], s_sel1 [N], s_ofs0 [N], s_ofs1 [N];
   logic [31:0] c_sel0 [N], c_sel1 [N], c_ofs0 [N], c_ofs1 [N];
   logic [1:0]  b_bits;
   logic [31:0] s_ext, c_ext;

   int vectors = 0;
   int miscompares = 0;
   int tick = 0;
   string cur_req = "R6";
   bit done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            s_sel0[i] <= 32'h7777_7777; s_sel1[i] <= 32'h7777_7777;
            s_ofs0[i] <= 32'hFEDC_BA98; s_ofs1[i] <= 32'h7654_3210;
            c_sel0[i] <= 32'h7777_7777; c_sel1[i] <= 32'h7777_7777;
            c_ofs0[i] <= 32'hFEDC_BA98; c_ofs1[i] <= 32'h7654_3210;
         end
         b_bits <= 2'b11;
         s_ext  <= '0;
         c_ext  <= '0;
      end else if (reg_wr) begin
         int a;
         a = int'(reg_addr) & ~3;
         if (a < N*32) begin
            int g, w;
            g = a / 32;
            w = (a % 32) / 4;
            case (w)
               0: s_sel0[g] <= reg_wdata;
               1: s_sel1[g] <= reg_wdata;
               2: s_ofs0[g] <= reg_wdata;
               3: s_ofs1[g] <= reg_wdata;
               4: if (g == 0) b_bits <= reg_wdata[1:0];
               5: if (reg_wdata == 32'd1) begin
                     c_sel0[g] <= s_sel0[g]; c_sel1[g] <= s_sel1[g];
                     c_ofs0[g] <= s_ofs0[g]; c_ofs1[g] <= s_ofs1[g];
                  end
               default: ;
            endcase
         end else if (a == 'h180) begin
            s_ext <= reg_wdata;
         end else if (a == 'h194 && reg_wdata == 32'd1) begin
            c_ext <= s_ext;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input int addr);
      int a = addr & ~3;
      if (a < N*32) begin
         int g = a / 32;
         case ((a % 32) / 4)
            0: return s_sel0[g];
            1: return s_sel1[g];
            2: return s_ofs0[g];
            3: return s_ofs1[g];
            4: return (g == 0) ? {30'd0, b_bits} : 32'd0;
            default: return 32'd0;
         endcase
      end
      if (a == 'h180) return s_ext;
      return 32'd0;
   endfunction

   task automatic fail(input string req, input string what, input int m,
                       input logic [31:0] act, input logic [31:0] exp);
      miscompares++;
      $display("FAIL %s/%s %s master %0d act %h exp %h", req, cur_req, what, m, act, exp);
   endtask

   task automatic check_all();
      vectors++;
      for (int m = 0; m < N; m++) begin
         logic [31:0] a, sw, ow, eaddr;
         int ap, code, eslave;
         bit eerr;
         a  = m_addr[m*32 +: 32];
         ap = int'(a[31:28]);
         sw = (ap < 8) ? c_sel1[m] : c_sel0[m];
         ow = (ap < 8) ? c_ofs1[m] : c_ofs0[m];
         code = int'((sw >> (4 * (ap % 8))) & 32'hF);
         if (m == 0 && ap == 0 && b_bits != 2'b00) begin
            eslave = 5; eerr = 1'b0; eaddr = a;        // R7
         end else begin
            eerr   = (code == 0) || (code > 10);
            eslave = eerr ? 0 : code;
            eaddr  = {((ow >> (4 * (ap % 8))) & 32'hF) << 28} | (a & 32'h0FFF_FFFF);
         end
         if (int'(m_slave[m*4 +: 4]) != eslave) fail("R1", "slave", m, 32'(m_slave[m*4 +: 4]), 32'(eslave));
         if (m_raddr[m*32 +: 32] != eaddr)      fail("R2", "raddr", m, m_raddr[m*32 +: 32], eaddr);
         if (m_derr[m] != eerr)                 fail("R3", "derr", m, 32'(m_derr[m]), 32'(eerr));
      end
      if (reg_rdata != exp_rd(int'(reg_addr))) fail("R5", "rdata", 0, reg_rdata, exp_rd(int'(reg_addr)));
      if (ext_cfg != c_ext)                    fail("R8", "ext", 0, ext_cfg, c_ext);
   endtask

   task automatic cyc(input bit wr, input int addr, input logic [31:0] data);
      @(negedge clk);
      reg_wr    = wr;
      reg_addr  = RA_W'(addr);
      reg_wdata = data;
      for (int m = 0; m < N; m++) begin
         logic [31:0] lo;
         lo = (32'(tick) * 32'h01F3_5A7B + 32'(m) * 32'h0111_1111) & 32'h0FFF_FFFF;
         m_addr[m*32 +: 32] = {4'((tick + m * 5) % 16), lo[27:0]};
      end
      #1;
      check_all();
      tick++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 'hFFC, 32'd0);
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      cyc(1'b1, addr, data);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R6: reset defaults, identity offsets, mirror on
      cur_req = "R6";
      idle(16);
      for (int m = 0; m < N; m++)
         for (int w = 0; w < 6; w++) cyc(1'b0, m * 32 + w * 4, 32'd0);

      // R4: staged writes on master 3 stay invisible
      cur_req = "R4";
      wr(3*32 + 'h04, 32'hA987_6543);
      wr(3*32 + 'h00, 32'hFEDC_B210);
      wr(3*32 + 'h0C, 32'h0123_4567);
      wr(3*32 + 'h08, 32'h89AB_CDEF);
      idle(4);
      wr(3*32 + 'h14, 32'd2);
      idle(16);

      // R1 R2 R3: commit and sweep every aperture
      cur_req = "R1";
      wr(3*32 + 'h14, 32'd1);
      idle(20);

      // R5: readback of staged and update registers
      cur_req = "R5";
      wr(3*32 + 'h04, 32'h1234_5678);
      for (int w = 0; w < 6; w++) cyc(1'b0, 3*32 + w * 4, 32'd0);
      cyc(1'b0, 'h194, 32'd0);
      cyc(1'b0, 'h1A0, 32'd0);
      idle(16);
      wr(3*32 + 'h14, 32'd1);
      idle(16);

      // R9: updating another master leaves master 5 alone
      cur_req = "R9";
      wr(5*32 + 'h04, 32'h1111_1111);
      wr(5*32 + 'h0C, 32'hEEEE_EEEE);
      wr(7*32 + 'h14, 32'd1);
      idle(16);
      wr(5*32 + 'h14, 32'd1);
      idle(16);

      // R7: boot mirror on master 0
      cur_req = "R7";
      wr('h04, 32'h7777_7772);
      wr('h14, 32'd1);
      idle(16);
      wr('h10, 32'hFFFF_FFFC);
      cyc(1'b0, 'h10, 32'd0);
      idle(16);
      wr('h10, 32'h0000_0002);
      idle(16);
      wr(4*32 + 'h10, 32'h0000_0000);
      idle(16);
      wr('h10, 32'h0000_0000);
      idle(16);

      // R8: extension word staging and commit
      cur_req = "R8";
      wr('h180, 32'hDEAD_BEEF);
      idle(3);
      cyc(1'b0, 'h180, 32'd0);
      wr('h194, 32'd0);
      idle(3);
      wr('h194, 32'd1);
      idle(3);
      wr('h180, 32'h0000_00A5);
      idle(2);
      wr('h194, 32'd1);
      idle(3);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule